// File: doc/BRIEF.md
# SIMD Width Beat Sequencer

The sequencer sits in front of a four-lane arithmetic pipeline and turns one vector instruction of any logical width (1, 2, 4, 8, 16 or 32 lanes of 32-bit data) into a series of four-lane micro-operations, called beats. For every beat it names, for each operand, the 32-byte register that holds the data and the lane offset inside that register. Operands wider than one register continue into the registers that follow the base register. It also produces the lane enable mask for the beat.

An instruction arrives with a valid/ready handshake. It carries a width code and one base register number per operand. Beats leave on a stream that has no backpressure, one beat per cycle. The final beat of an instruction is flagged. A waiting instruction is taken in that same cycle, so instructions of mixed widths run with no idle cycle between them. An instruction whose width code is undefined, or whose operand would run past the last register, is consumed and dropped with a one-cycle error pulse.

Top module: `simd_beat_sequencer`

## Requirements
- R1: The width code `in_width` selects 2^code lanes for codes 0 to 5. Codes 6 and 7 are rejected: the instruction is consumed, no beat is issued, and `err` pulses.
- R2: An accepted instruction issues max(1, lanes/4) beats on consecutive cycles. `uop_last` is high on the final beat only.
- R3: `uop_mask` bit i enables physical lane i. It is 4'b0001 for 1 lane, 4'b0011 for 2 lanes and 4'b1111 for every wider width.
- R4: In beat k, every operand n addresses register base_n + k/2 at lane offset (k mod 2)*4. A 16-lane operand thus covers two adjacent registers and a 32-lane operand covers four.
- R5: The first beat appears on the cycle after the handshake. `busy` equals `uop_valid`.
- R6: `in_ready` is high when no beat is presented, or when the presented beat is the last one, so back-to-back instructions leave no gap.
- R7: If any operand would use a register past 127 (base + registers spanned > 128), the instruction is consumed and dropped. `err` is high on the cycle after the handshake, and no beat is presented on that cycle.
- R8: During and right after reset, `uop_valid`, `uop_last`, `busy` and `err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction taken when high together with in_valid |
| in_width | input | 3 | Width code, lanes = 2^code |
| in_base | input | 21 | Base register per operand, operand n in bits [7n+6:7n] |
| uop_valid | output | 1 | A beat is presented |
| uop_reg | output | 21 | Register per operand for this beat, same packing as in_base |
| uop_lane_off | output | 3 | First lane inside the register (0 or 4) |
| uop_mask | output | 4 | Physical lane enables |
| uop_last | output | 1 | Final beat of the instruction |
| busy | output | 1 | Beats outstanding |
| err | output | 1 | One-cycle pulse for a dropped instruction |

## Verification
The bench uses the default parameters: 128 registers of eight lanes, a four-lane pipeline, widths up to 32 lanes and three operands. With these values every width code, both rejection causes, and bases right at the top of the register file (124 for 32 lanes, 126 for 16, 127 for 8) can be reached. It checks operand 0 and operand 2 separately, so an overflow caused by a single operand is caught. The beat count reaches eight, so both register pairing and the lane offset toggling run several times within one instruction.

// File: rtl/simd_seq_pkg.sv
package simd_seq_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        WCODE_1  = 3'd0,
        WCODE_2  = 3'd1,
        WCODE_4  = 3'd2,
        WCODE_8  = 3'd3,
        WCODE_16 = 3'd4,
        WCODE_32 = 3'd5
    } wcode_e;

endpackage

// File: rtl/simd_width_decode.sv
module simd_width_decode
    import simd_seq_pkg::*;
#(
    parameter int FPU_LANES = 4,
    parameter int REG_LANES = 8,
    parameter int MAX_LANES = 32,
    parameter int BEAT_W    = 3,
    parameter int SPAN_W    = 3
) (
    input  logic [CODE_W-1:0]    code_i,
    output logic                 legal_o,
    output logic [BEAT_W-1:0]    last_beat_o,
    output logic [SPAN_W-1:0]    span_o,
    output logic [FPU_LANES-1:0] mask_o
);
    localparam int LOG_MAX = $clog2(MAX_LANES);

    int lanes;
    int beats;
    int span;

    always_comb begin
        lanes       = 1 << int'(code_i);
        legal_o     = int'(code_i) <= LOG_MAX;
        beats       = (lanes <= FPU_LANES) ? 1 : lanes / FPU_LANES;
        span        = (lanes <= REG_LANES) ? 1 : lanes / REG_LANES;
        last_beat_o = BEAT_W'(beats - 1);
        span_o      = SPAN_W'(span);
        if (lanes >= FPU_LANES) begin
            mask_o = '1;
        end else begin
            mask_o = FPU_LANES'((1 << lanes) - 1);
        end
    end

endmodule

// File: rtl/simd_operand_range.sv
module simd_operand_range #(
    parameter int NUM_REGS = 128,
    parameter int REG_W    = 7,
    parameter int SPAN_W   = 3
) (
    input  logic [REG_W-1:0]  base_i,
    input  logic [SPAN_W-1:0] span_i,
    output logic              over_o
);
    localparam logic [REG_W:0] LIMIT = (REG_W+1)'(NUM_REGS);

    logic [REG_W:0] end_excl;

    always_comb begin
        end_excl = {1'b0, base_i} + (REG_W+1)'(span_i);
        over_o   = end_excl > LIMIT;
    end

endmodule

// File: rtl/simd_operand_addr.sv
module simd_operand_addr #(
    parameter int FPU_LANES = 4,
    parameter int REG_LANES = 8,
    parameter int REG_W     = 7,
    parameter int BEAT_W    = 3,
    parameter int OFF_W     = 3
) (
    input  logic [REG_W-1:0]  base_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [REG_W-1:0]  reg_o,
    output logic [OFF_W-1:0]  off_o
);
    localparam int BEATS_PER_REG = REG_LANES / FPU_LANES;

    always_comb begin
        reg_o = base_i + REG_W'(int'(beat_i) / BEATS_PER_REG);
        off_o = OFF_W'((int'(beat_i) % BEATS_PER_REG) * FPU_LANES);
    end

endmodule

// File: rtl/simd_beat_sequencer.sv
module simd_beat_sequencer
    import simd_seq_pkg::*;
#(
    parameter int NUM_REGS  = 128,
    parameter int REG_LANES = 8,
    parameter int FPU_LANES = 4,
    parameter int MAX_LANES = 32,
    parameter int NUM_OPS   = 3,
    localparam int REG_W     = $clog2(NUM_REGS),
    localparam int OFF_W     = $clog2(REG_LANES),
    localparam int MAX_BEATS = MAX_LANES / FPU_LANES,
    localparam int BEAT_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
    localparam int SPAN_W    = $clog2(MAX_LANES / REG_LANES + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [CODE_W-1:0]        in_width,
    input  logic [NUM_OPS*REG_W-1:0] in_base,
    output logic                     uop_valid,
    output logic [NUM_OPS*REG_W-1:0] uop_reg,
    output logic [OFF_W-1:0]         uop_lane_off,
    output logic [FPU_LANES-1:0]     uop_mask,
    output logic                     uop_last,
    output logic                     busy,
    output logic                     err
);

    typedef struct packed {
        logic                            act;
        logic [BEAT_W-1:0]               beat;
        logic [BEAT_W-1:0]               last_beat;
        logic [FPU_LANES-1:0]            mask;
        logic [NUM_OPS-1:0][REG_W-1:0]   base;
        logic                            err;
    } seq_state_t;

    seq_state_t st_q, st_d;

    logic                 dec_legal;
    logic [BEAT_W-1:0]    dec_last;
    logic [SPAN_W-1:0]    dec_span;
    logic [FPU_LANES-1:0] dec_mask;
    logic [NUM_OPS-1:0]   op_over;
    logic [OFF_W-1:0]     op_off [NUM_OPS];
    logic                 at_last;
    logic                 accept;
    logic                 reject;

    simd_width_decode #(
        .FPU_LANES (FPU_LANES),
        .REG_LANES (REG_LANES),
        .MAX_LANES (MAX_LANES),
        .BEAT_W    (BEAT_W),
        .SPAN_W    (SPAN_W)
    ) u_decode (
        .code_i      (in_width),
        .legal_o     (dec_legal),
        .last_beat_o (dec_last),
        .span_o      (dec_span),
        .mask_o      (dec_mask)
    );

    for (genvar n = 0; n < NUM_OPS; n++) begin : g_op
        simd_operand_range #(
            .NUM_REGS (NUM_REGS),
            .REG_W    (REG_W),
            .SPAN_W   (SPAN_W)
        ) u_range (
            .base_i (in_base[n*REG_W +: REG_W]),
            .span_i (dec_span),
            .over_o (op_over[n])
        );

        simd_operand_addr #(
            .FPU_LANES (FPU_LANES),
            .REG_LANES (REG_LANES),
            .REG_W     (REG_W),
            .BEAT_W    (BEAT_W),
            .OFF_W     (OFF_W)
        ) u_addr (
            .base_i (st_q.base[n]),
            .beat_i (st_q.beat),
            .reg_o  (uop_reg[n*REG_W +: REG_W]),
            .off_o  (op_off[n])
        );
    end

    always_comb begin
        at_last      = st_q.act && (st_q.beat == st_q.last_beat);
        in_ready     = !st_q.act || at_last;
        accept       = in_valid && in_ready;
        reject       = !dec_legal || (|op_over);
        uop_valid    = st_q.act;
        busy         = st_q.act;
        uop_last     = at_last;
        uop_mask     = st_q.act ? st_q.mask : '0;
        uop_lane_off = op_off[0];
        err          = st_q.err;

        st_d     = st_q;
        st_d.err = 1'b0;
        if (accept) begin
            if (reject) begin
                st_d.act = 1'b0;
                st_d.err = 1'b1;
            end else begin
                st_d.act       = 1'b1;
                st_d.beat      = '0;
                st_d.last_beat = dec_last;
                st_d.mask      = dec_mask;
                st_d.base      = in_base;
            end
        end else if (st_q.act) begin
            if (at_last) begin
                st_d.act = 1'b0;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_first_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && dec_legal && !(|op_over))
        |=> (uop_valid && uop_lane_off == '0 && uop_reg == $past(in_base)));

    assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !uop_valid);

    assert_narrow_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_width == WCODE_1 && !(|op_over))
        |=> (uop_mask == FPU_LANES'(1)));

    assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_last) |-> !in_ready);

    assert_pair_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_last && uop_lane_off != '0)
        |=> (uop_reg[REG_W-1:0] == $past(uop_reg[REG_W-1:0]) + 1'b1
             && uop_lane_off == '0));

    assert_same_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_last && uop_lane_off == '0)
        |=> ($stable(uop_reg) && uop_lane_off == OFF_W'(FPU_LANES)));

    assert_continue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_last) |=> uop_valid);

endmodule

// File: tb/simd_beat_sequencer_bench.sv
`timescale 1ns/1ps
module simd_beat_sequencer_bench;

    localparam int NOPS = 3;
    localparam int RW   = 7;
    localparam int NCYC = 4000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [2:0]      in_width = '0;
    logic [NOPS*RW-1:0] in_base = '0;
    logic            uop_valid;
    logic [NOPS*RW-1:0] uop_reg;
    logic [2:0]      uop_lane_off;
    logic [3:0]      uop_mask;
    logic            uop_last;
    logic            busy;
    logic            err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    simd_beat_sequencer u_simd_beat_sequencer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_width(in_width), .in_base(in_base), .uop_valid(uop_valid),
        .uop_reg(uop_reg), .uop_lane_off(uop_lane_off), .uop_mask(uop_mask),
        .uop_last(uop_last), .busy(busy), .err(err)
    );

    // reference state
    bit      m_act = 0;
    int      m_beat = 0;
    int      m_code = 0;
    int      m_base [NOPS];
    bit      m_err = 0;

    function automatic int lanes_of(int c);  return 1 << c; endfunction
    function automatic int beats_of(int c);  return (c <= 2) ? 1 : (1 << (c - 2)); endfunction
    function automatic int span_of(int c);   return (c <= 3) ? 1 : (1 << (c - 3)); endfunction
    function automatic int mask_of(int c);
        return (c == 0) ? 1 : (c == 1) ? 3 : 15;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare_outputs();
        bit e_last;
        e_last = m_act && (m_beat == beats_of(m_code) - 1);
        chk(uop_valid == m_act, "R2 uop_valid", int'(uop_valid), int'(m_act));
        chk(busy == m_act, "R5 busy", int'(busy), int'(m_act));
        chk(uop_last == e_last, "R2 uop_last", int'(uop_last), int'(e_last));
        chk(in_ready == (!m_act || e_last), "R6 in_ready", int'(in_ready), int'(!m_act || e_last));
        chk(err == m_err, "R7/R1 err", int'(err), int'(m_err));
        if (m_act && uop_valid) begin
            chk(int'(uop_mask) == mask_of(m_code), "R3 mask", int'(uop_mask), mask_of(m_code));
            chk(int'(uop_lane_off) == (m_beat % 2) * 4, "R4 lane offset",
                int'(uop_lane_off), (m_beat % 2) * 4);
            for (int n = 0; n < NOPS; n++) begin
                chk(int'(uop_reg[n*RW +: RW]) == m_base[n] + m_beat / 2, "R4 register",
                    int'(uop_reg[n*RW +: RW]), m_base[n] + m_beat / 2);
            end
        end
    endtask

    task automatic step_model();
        bit e_last, acc, bad;
        e_last = m_act && (m_beat == beats_of(m_code) - 1);
        acc = in_valid && (!m_act || e_last);
        bad = (int'(in_width) > 5);
        if (!bad) begin
            for (int n = 0; n < NOPS; n++)
                if (int'(in_base[n*RW +: RW]) + span_of(int'(in_width)) > 128) bad = 1;
        end
        m_err = acc && bad;
        if (acc && !bad) begin
            m_act = 1; m_beat = 0; m_code = int'(in_width);
            for (int n = 0; n < NOPS; n++) m_base[n] = int'(in_base[n*RW +: RW]);
        end else if (acc) begin
            m_act = 0;
        end else if (m_act) begin
            if (e_last) m_act = 0;
            else m_beat++;
        end
    endtask

    // directed corner cases: code, base0, base1, base2
    localparam int ND = 14;
    int d_code [ND] = '{5, 5, 4, 4, 3, 0, 1, 2, 6, 7, 5, 4, 0, 5};
    int d_b0   [ND] = '{124, 125, 126, 127, 127, 5, 9, 3, 0, 0, 0, 10, 127, 0};
    int d_b1   [ND] = '{0, 0, 10, 0, 127, 6, 9, 4, 0, 0, 0, 126, 127, 0};
    int d_b2   [ND] = '{96, 0, 20, 0, 127, 7, 9, 5, 0, 0, 125, 40, 127, 124};

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        bit pending;
        int didx;
        int r;
        pending = 0;
        didx = 0;
        r = $urandom(32'h5eed);
        for (int n = 0; n < NOPS; n++) m_base[n] = 0;
        repeat (3) @(negedge clk);
        // R8: state while held in reset
        chk(uop_valid == 0, "R8 uop_valid in reset", int'(uop_valid), 0);
        chk(in_ready == 1, "R8 in_ready in reset", int'(in_ready), 1);
        chk(busy == 0, "R8 busy in reset", int'(busy), 0);
        chk(err == 0, "R8 err in reset", int'(err), 0);
        chk(uop_last == 0, "R8 uop_last in reset", int'(uop_last), 0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            @(negedge clk);
            compare_outputs();
            if (!pending) begin
                if (didx < ND) begin
                    in_width = 3'(d_code[didx]);
                    in_base  = {RW'(d_b2[didx]), RW'(d_b1[didx]), RW'(d_b0[didx])};
                    didx++;
                    pending = 1;
                end else if ($urandom % 10 < 7) begin
                    if ($urandom % 8 == 0) in_width = 3'(6 + $urandom % 2);
                    else in_width = 3'($urandom % 6);
                    for (int n = 0; n < NOPS; n++) begin
                        if ($urandom % 4 == 0) in_base[n*RW +: RW] = RW'(120 + $urandom % 8);
                        else in_base[n*RW +: RW] = RW'($urandom % 128);
                    end
                    pending = 1;
                end
            end
            in_valid = pending;
            if (pending && (!m_act || (m_beat == beats_of(m_code) - 1))) pending = 0;
            step_model();
        end
        @(negedge clk);
        compare_outputs();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule